// File: doc/BRIEF.md
# Fractional Oversampling Tick Generator

This block turns a reference clock into the oversampling strobe that paces a serial transmitter and receiver. Software loads a 16-bit integer divisor as two bytes and writes a control byte. That byte holds a 4-bit fraction in sixteenths and a 2-bit oversampling mode (16, 8 or 4 samples per bit). A pin picks either the raw reference clock or a quarter-rate enable as the counting base. The block emits `sample_tick`, a one-cycle strobe per oversample period. Over any run of sixteen ticks, the periods average divisor + fraction/16 counting-base cycles.

The fraction is spread by a 4-bit phase accumulator. Each tick adds the fraction, and a tick whose addition carries out of the accumulator lasts one base cycle longer. A second strobe, `bit_strobe`, marks every 16th, 8th or 4th tick so a transmitter can find its bit boundaries. Each register write restarts the counters and the accumulator, so a new rate starts from a clean phase.

Top module: `fbrg_top`

## Requirements
- R1: After reset the divisor is 1, the fraction is 0, the mode is 16X and counting starts at the release edge. With `presc_sel` low, `sample_tick` is high in every cycle after release, and `bit_strobe` is high on ticks 16, 32 and so on.
- R2: A write with `wr_addr` 0 loads the divisor low byte and `wr_addr` 1 loads the divisor high byte. With `wr_addr` 2, bits [3:0] load the fraction and bits [5:4] load the mode, and bits [7:6] are ignored. A write with `wr_addr` 3 has no effect on any output, and the tick timing continues unchanged.
- R3: With fraction 0 and divisor D, the first tick comes D base cycles after the restarting write, and each later tick comes D base cycles after the one before.
- R4: A divisor of 0 behaves as a divisor of 1.
- R5: With fraction F, tick k (counted from 1 after a restart) is lengthened by one base cycle exactly when floor(k·F/16) > floor((k−1)·F/16). Tick k is therefore high k·D + floor(k·F/16) base cycles after the restart.
- R6: With `presc_sel` high, one base cycle equals four reference clocks, so every interval of R3 and R5 grows fourfold. With `presc_sel` low, one base cycle is one reference clock.
- R7: `bit_strobe` is high on tick k exactly when k is a multiple of N. N is 16 for mode 00, 8 for mode 01, 4 for mode 10 and 16 for mode 11.
- R8: `bit_strobe` is never high outside a tick cycle, and each `sample_tick` pulse lasts one reference clock.
- R9: Any write to address 0, 1 or 2 restarts the tick counter, the phase accumulator, the prescaler and the tick count per bit. Timing then follows R5 from that write's clock edge, and no tick is issued on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 fraction/mode, 3 unused |
| wr_data | input | BYTE_W | Write data |
| presc_sel | input | 1 | 0: count every clock, 1: count every fourth clock |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_strobe | output | 1 | One-cycle strobe on every Nth tick |

## Verification
A corrupted tick counter or phase accumulator moves the very next `sample_tick` by at least one base cycle. The bench therefore compares every tick's absolute cycle against the closed-form position k·D + floor(k·F/16) taken from the last write. A mistake in the per-bit tick count shows at the first `bit_strobe`, no later than the 16th tick. A missed restart shows on the first tick after a write made in the middle of a period, because that tick lands at the old phase. An early or extra pulse between expected ticks is flagged in the cycle where it occurs.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;

   typedef enum logic [1:0] {
      OS_X16 = 2'b00,
      OS_X8  = 2'b01,
      OS_X4  = 2'b10,
      OS_RSV = 2'b11
   } os_mode_e;

   typedef enum logic [1:0] {
      RA_DIV_LO = 2'd0,
      RA_DIV_HI = 2'd1,
      RA_FRAC   = 2'd2,
      RA_NONE   = 2'd3
   } reg_addr_e;

   localparam int unsigned OS_MAX = 16;

   // Ticks per bit for each oversampling mode; the reserved code runs as 16X.
   function automatic int unsigned os_ticks(os_mode_e m);
      case (m)
         OS_X8:   return 8;
         OS_X4:   return 4;
         default: return OS_MAX;
      endcase
   endfunction

endpackage

// File: rtl/fbrg_regs.sv
module fbrg_regs
   import fbrg_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int FRAC_W = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [1:0]            wr_addr,
   input  logic [BYTE_W-1:0]     wr_data,
   output logic [2*BYTE_W-1:0]   divisor,
   output logic [FRAC_W-1:0]     frac,
   output os_mode_e              mode,
   output logic                  restart
);
   localparam int MODE_LSB = FRAC_W;
   localparam int MODE_MSB = FRAC_W + 1;

   generate
      if (BYTE_W < FRAC_W + 2) begin : g_bad_width
         $error("fbrg_regs: control byte too narrow for fraction and mode");
      end
   endgenerate

   logic [BYTE_W-1:0] div_lo_q, div_hi_q;
   logic [FRAC_W-1:0] frac_q;
   logic [1:0]        mode_q;

   assign restart = wr_en && (wr_addr != RA_NONE);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         div_lo_q <= BYTE_W'(1);
         div_hi_q <= '0;
         frac_q   <= '0;
         mode_q   <= OS_X16;
      end else if (wr_en) begin
         case (wr_addr)
            RA_DIV_LO: div_lo_q <= wr_data;
            RA_DIV_HI: div_hi_q <= wr_data;
            RA_FRAC: begin
               frac_q <= wr_data[FRAC_W-1:0];
               mode_q <= wr_data[MODE_MSB:MODE_LSB];
            end
            default: ;
         endcase
      end
   end

   assign divisor = {div_hi_q, div_lo_q};
   assign frac    = frac_q;
   assign mode    = os_mode_e'(mode_q);

   // R2: the unused address never alters stored configuration
   a_r2_none_ignored: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == RA_NONE) |=> ($stable(divisor) && $stable(frac) && $stable(mode)));

   // R2: a low-byte write lands in the low half of the divisor
   a_r2_lo_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == RA_DIV_LO) |=> (divisor[BYTE_W-1:0] == $past(wr_data)));

endmodule

// File: rtl/fbrg_prescale.sv
module fbrg_prescale #(
   parameter int PRESC_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic sel,
   input  logic restart,
   output logic ce
);
   generate
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("fbrg_prescale: PRESC_DIV must be at least 1");
      end else if (PRESC_DIV == 1) begin : g_pass
         logic unused_in;
         assign unused_in = sel ^ restart ^ clk ^ rst;
         assign ce = 1'b1;
      end else begin : g_count
         localparam int PC_W = $clog2(PRESC_DIV);
         localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESC_DIV - 1);
         logic [PC_W-1:0] pc_q;

         always_ff @(posedge clk or posedge rst) begin
            if (rst)                  pc_q <= '0;
            else if (restart)         pc_q <= '0;
            else if (pc_q == PC_LAST) pc_q <= '0;
            else                      pc_q <= pc_q + PC_W'(1);
         end

         assign ce = sel ? (pc_q == PC_LAST) : 1'b1;

         // R6: in divided mode an enable is never followed directly by another
         a_r6_ce_gap: assert property (@(posedge clk) disable iff (rst)
            (sel && ce && !restart) |=> (!ce || !sel));
      end
   endgenerate

endmodule

// File: rtl/fbrg_tick_gen.sv
module fbrg_tick_gen #(
   parameter int DIV_W  = 16,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              restart,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [FRAC_W-1:0] frac,
   output logic              sample_tick
);
   generate
      if (FRAC_W < 1 || DIV_W < 2) begin : g_bad_width
         $error("fbrg_tick_gen: widths out of range");
      end
   endgenerate

   logic [DIV_W-1:0]  cnt_q;
   logic [FRAC_W-1:0] acc_q;
   logic              tick_q;

   logic [DIV_W-1:0]  eff_div;
   logic [FRAC_W:0]   acc_sum;
   logic              carry;
   logic [DIV_W:0]    last_cnt;
   logic              hit;

   assign eff_div  = (divisor == '0) ? DIV_W'(1) : divisor;
   assign acc_sum  = {1'b0, acc_q} + {1'b0, frac};
   assign carry    = acc_sum[FRAC_W];
   assign last_cnt = {1'b0, eff_div} - (DIV_W+1)'(1) + (DIV_W+1)'(carry);
   assign hit      = ce && ({1'b0, cnt_q} == last_cnt);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else if (restart) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= hit;
         if (hit) begin
            cnt_q <= '0;
            acc_q <= acc_sum[FRAC_W-1:0];
         end else if (ce) begin
            cnt_q <= cnt_q + DIV_W'(1);
         end
      end
   end

   assign sample_tick = tick_q;

   // R3: the period counter never runs past one lengthened period
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= eff_div);

   // R8: a tick only follows a counting enable that was not a restart
   a_r8_tick_after_ce: assert property (@(posedge clk) disable iff (rst)
      sample_tick |-> $past(ce && !restart));

   // R9: the edge of a restarting write never yields a tick
   a_r9_restart_quiet: assert property (@(posedge clk) disable iff (rst)
      restart |=> !sample_tick);

endmodule

// File: rtl/fbrg_bit_gen.sv
module fbrg_bit_gen
   import fbrg_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     restart,
   input  logic     sample_tick,
   input  os_mode_e mode,
   output logic     bit_strobe
);
   localparam int TC_W = $clog2(OS_MAX);

   logic [TC_W-1:0] tcnt_q;
   logic [TC_W-1:0] n_last;

   assign n_last     = TC_W'(os_ticks(mode) - 1);
   assign bit_strobe = sample_tick && (tcnt_q == n_last);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)              tcnt_q <= '0;
      else if (restart)     tcnt_q <= '0;
      else if (bit_strobe)  tcnt_q <= '0;
      else if (sample_tick) tcnt_q <= tcnt_q + TC_W'(1);
   end

   // R7: the per-bit tick count stays inside the selected mode's range
   a_r7_tcnt_bound: assert property (@(posedge clk) disable iff (rst)
      tcnt_q <= n_last);

   // R7: a bit boundary starts a fresh count
   a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
      (bit_strobe && !restart) |=> (tcnt_q == '0));

endmodule

// File: rtl/fbrg_top.sv
module fbrg_top
   import fbrg_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int FRAC_W    = 4,
   parameter int PRESC_DIV = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              presc_sel,
   output logic              sample_tick,
   output logic              bit_strobe
);
   localparam int DIV_W = 2 * BYTE_W;

   logic [DIV_W-1:0]  divisor;
   logic [FRAC_W-1:0] frac;
   os_mode_e          mode;
   logic              restart;
   logic              ce;

   fbrg_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) i_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .divisor(divisor), .frac(frac), .mode(mode), .restart(restart)
   );

   fbrg_prescale #(.PRESC_DIV(PRESC_DIV)) i_presc (
      .clk(clk), .rst(rst), .sel(presc_sel), .restart(restart), .ce(ce)
   );

   fbrg_tick_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_tick (
      .clk(clk), .rst(rst), .ce(ce), .restart(restart),
      .divisor(divisor), .frac(frac), .sample_tick(sample_tick)
   );

   fbrg_bit_gen i_bit (
      .clk(clk), .rst(rst), .restart(restart), .sample_tick(sample_tick),
      .mode(mode), .bit_strobe(bit_strobe)
   );

   // R8: a bit boundary is always a tick cycle
   a_r8_strobe_on_tick: assert property (@(posedge clk) disable iff (rst)
      bit_strobe |-> sample_tick);

endmodule

// File: tb/test_fbrg_top.sv
module test_fbrg_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       presc_sel = 1'b0;
   logic       sample_tick, bit_strobe;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   int base = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fbrg_top i_fbrg_top (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .presc_sel(presc_sel), .sample_tick(sample_tick), .bit_strobe(bit_strobe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr_raw(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_raw(a, d);
      base = cyc;
   endtask

   task automatic cfg(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] fm);
      wr(2'd1, hi);
      wr(2'd0, lo);
      wr(2'd2, fm);
   endtask

   // Closed-form tick positions measured from the last restarting write.
   task automatic expect_ticks(input int d, input int f, input int presc, input int n_os,
                               input int n, input string tag);
      int deff;
      deff = (d == 0) ? 1 : d;
      for (int k = 1; k <= n; k++) begin
         int expt;
         int early;
         early = 0;
         expt = base + presc * (k * deff + (k * f) / 16);
         while (cyc < expt) begin
            @(negedge clk);
            if (cyc < expt && (sample_tick || bit_strobe)) early = cyc;
         end
         check(sample_tick === 1'b1 && early == 0, tag, early == 0 ? int'(sample_tick) : early, expt);
         check(bit_strobe === ((k % n_os) == 0), {tag, " R7 strobe"}, int'(bit_strobe), int'((k % n_os) == 0));
      end
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      base = cyc;
      expect_ticks(1, 0, 1, 16, 33, "R1 reset rate");
   endtask

   task automatic t_integer;
      presc_sel = 1'b0;
      cfg(8'd5, 8'd0, 8'h00);
      wr_raw(2'd3, 8'hFF);   // R2 ignored address, must not restart
      expect_ticks(5, 0, 1, 16, 18, "R3 R2 integer D=5");
   endtask

   task automatic t_high_byte;
      cfg(8'd2, 8'd1, 8'h00);
      expect_ticks(258, 0, 1, 16, 3, "R2 high byte D=258");
   endtask

   task automatic t_zero_div;
      cfg(8'd0, 8'd0, 8'h00);
      expect_ticks(0, 0, 1, 16, 17, "R4 divisor zero");
   endtask

   task automatic t_frac_8x;
      cfg(8'd3, 8'd0, 8'h15);
      expect_ticks(3, 5, 1, 8, 32, "R5 frac5 8X");
      cfg(8'd3, 8'd0, 8'hD1);   // bits [7:6] ignored, mode 01, fraction 1
      expect_ticks(3, 1, 1, 8, 24, "R5 R2 frac1 8X");
   endtask

   task automatic t_frac_4x;
      cfg(8'd2, 8'd0, 8'h2F);
      expect_ticks(2, 15, 1, 4, 20, "R5 frac15 4X");
   endtask

   task automatic t_presc;
      presc_sel = 1'b1;
      cfg(8'd2, 8'd0, 8'h33);   // mode 11 runs as 16X
      expect_ticks(2, 3, 4, 16, 17, "R6 R7 prescale");
      presc_sel = 1'b0;
   endtask

   task automatic t_restart;
      cfg(8'd7, 8'd0, 8'h00);
      repeat (10) @(negedge clk);
      wr(2'd2, 8'h03);
      expect_ticks(7, 3, 1, 16, 18, "R9 restart");
   endtask

   initial begin
      t_reset();
      t_integer();
      t_high_byte();
      t_zero_div();
      t_frac_8x();
      t_frac_4x();
      t_presc();
      t_restart();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule